// File: doc/BRIEF.md
# Runtime-Precision Fixed-Point Arithmetic Unit

This unit performs two's-complement addition and multiplication on raw signed words whose binary point is chosen while the chip runs. The operands are plain W-bit integers. An integer-bits setting, held in a small configuration register, says how many of the W bits sit above the binary point. A multiply forms the full double-width product and rescales it by an arithmetic right shift of (W minus integer bits). An add ignores the setting, because two operands in the same format add directly.

The unit is meant for one arithmetic engine that many network layers share. Software loads the integer-bits value before each layer starts and leaves it alone while that layer streams operations through. Each operation is presented with a valid strobe and an operation select. Its result appears on a fixed two-cycle schedule for both operations, and a new operation may be issued every cycle. No rounding and no overflow handling take place: high bits that do not fit are dropped, so the result wraps, and low bits shifted out are lost, which rounds toward negative infinity.

Top module: `rpfx_unit`

## Requirements
- R1: After a synchronous active-low reset, out_valid and out_data read 0 and the integer-bits setting is 8. With W=16, a multiply of 0x0100 by 0x0100 then yields 0x0100.
- R2: With op_sel=0 (add), out_data is the low W bits of in_a+in_b, whatever the integer-bits setting is.
- R3: With op_sel=1 (multiply), both operands are sign-extended to 2W bits, multiplied, arithmetically shifted right by (W minus integer bits), and the low W bits are kept. At W=16 with 8 integer bits this matches a 16-bit format with 8 fraction bits under truncate and wrap.
- R4: Bits shifted out of the product are discarded, so a negative result rounds toward negative infinity. For example, 0xFFFF times 0x0001 with 8 integer bits gives 0xFFFF.
- R5: High product bits beyond W after the shift are discarded, so the result wraps. For example, 0x7F00 times 0x0200 with 8 integer bits gives 0xFE00.
- R6: out_valid is high exactly two rising edges after the edge that samples in_valid high, for both operations. Operations issued on consecutive cycles return in order on consecutive cycles.
- R7: A cfg_load carrying a value from 0 to W updates the integer-bits setting when the unit is idle. The new value applies to every operation sampled on a later edge. Value 0 shifts by W, and value W shifts by 0.
- R8: A cfg_load is ignored when in_valid is high on the same edge or when an operation is still in the input stage.
- R9: A cfg_load carrying a value greater than W is ignored, and the previous setting stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation request strobe |
| op_sel | input | 1 | 0 = add, 1 = multiply |
| in_a | input | W | First operand, raw two's-complement |
| in_b | input | W | Second operand, raw two's-complement |
| cfg_load | input | 1 | Load strobe for the integer-bits setting |
| cfg_value | input | $clog2(W+1) | New integer-bits value |
| out_valid | output | 1 | Result strobe |
| out_data | output | W | Result word |

## Verification
A configuration load and an operation issue can meet on the same clock edge. A load can also arrive in the cycle after an issue, while that operation still sits in the input stage. The bench provokes both cases by raising cfg_load together with a multiply, and then one cycle after a multiply. It judges them by the product scaling: the colliding multiply and the multiplies after it must keep the old shift (0x0010 squared gives 0x0010 with 12 integer bits rather than 0x0001 with 8). A clean load on an idle edge must change the scaling for the very next operation.

// File: rtl/rpfx_pkg.sv
// Package: shared types for the runtime-precision fixed-point unit.
// Assumes: nothing beyond IEEE 1800-2017.
package rpfx_pkg;
    // Operation select encoding, as seen on the op_sel port.
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_MUL = 1'b1
    } rpfx_op_e;

    // Width of a value that can hold 0..w inclusive.
    function automatic int ibits_width(input int w);
        return $clog2(w + 1);
    endfunction
endpackage

// File: rtl/rpfx_in_stage.sv
// Module: input register stage. Captures one operation per cycle.
// Assumes: the operands are only meaningful when s1_valid is high.
module rpfx_in_stage #(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_op,
    input  logic [W-1:0]         in_a,
    input  logic [W-1:0]         in_b,
    output logic                 s1_valid,
    output rpfx_pkg::rpfx_op_e   s1_op,
    output logic [W-1:0]         s1_a,
    output logic [W-1:0]         s1_b
);
    // Valid flag: follows in_valid one cycle later, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= in_valid;
    end

    // Operand capture: loads only on an accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op <= rpfx_pkg::OP_ADD;
            s1_a  <= '0;
            s1_b  <= '0;
        end else if (in_valid) begin
            s1_op <= rpfx_pkg::rpfx_op_e'(in_op);
            s1_a  <= in_a;
            s1_b  <= in_b;
        end
    end
endmodule

// File: rtl/rpfx_cfg_reg.sv
// Module: integer-bits configuration register.
// Assumes: busy is high whenever an operation is entering or inside the
// input stage. A load is taken only when idle and in range, so the
// setting never changes under an operation.
module rpfx_cfg_reg #(
    parameter int W       = 16,
    parameter int IBW     = 5,
    parameter int DEF_IB  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_load,
    input  logic [IBW-1:0] cfg_value,
    input  logic           busy,
    output logic [IBW-1:0] ibits
);
    localparam logic [IBW-1:0] MAX_IB = IBW'(W);
    localparam logic [IBW-1:0] RST_IB = IBW'(DEF_IB);

    logic take;

    // Acceptance: idle unit and a legal value.
    always_comb take = cfg_load && !busy && (cfg_value <= MAX_IB);

    // Setting register: reset default, otherwise load on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)    ibits <= RST_IB;
        else if (take) ibits <= cfg_value;
    end
endmodule

// File: rtl/rpfx_mul_scale.sv
// Module: widening signed multiply followed by a variable arithmetic
// right shift of (W - ibits), built as a log-depth barrel shifter.
// Assumes: ibits <= W (guaranteed by rpfx_cfg_reg). Purely combinational.
module rpfx_mul_scale #(
    parameter int W   = 16,
    parameter int IBW = 5
) (
    input  logic [W-1:0]   mul_a,
    input  logic [W-1:0]   mul_b,
    input  logic [IBW-1:0] ibits,
    output logic [W-1:0]   mul_res
);
    localparam int PW = 2 * W;
    localparam logic [IBW-1:0] MAX_IB = IBW'(W);

    logic signed [PW-1:0] ext_a;
    logic signed [PW-1:0] ext_b;
    logic signed [PW-1:0] prod;
    logic [IBW-1:0]       shamt;
    logic signed [PW-1:0] stg [0:IBW];

    // Sign extension and full-width product.
    always_comb begin
        ext_a = {{W{mul_a[W-1]}}, mul_a};
        ext_b = {{W{mul_b[W-1]}}, mul_b};
        prod  = ext_a * ext_b;
        shamt = MAX_IB - ibits;
    end

    assign stg[0] = prod;

    // Barrel stages: stage g shifts by 2**g when its amount bit is set.
    for (genvar g = 0; g < IBW; g++) begin : g_shift
        localparam int SH = 1 << g;
        assign stg[g+1] = shamt[g] ? (stg[g] >>> SH) : stg[g];
    end

    // Keep the low word, which drops the wrapped high bits.
    assign mul_res = stg[IBW][W-1:0];
endmodule

// File: rtl/rpfx_unit.sv
// Module: top of the runtime-precision fixed-point unit.
// Registered inputs, then an add or a rescaled multiply, then a
// registered output. Both operations take two cycles from in_valid to
// out_valid. Assumes the integer-bits setting is loaded between layers.
module rpfx_unit #(
    parameter int W      = 16,
    parameter int DEF_IB = 8,
    localparam int IBW   = rpfx_pkg::ibits_width(W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           op_sel,
    input  logic [W-1:0]   in_a,
    input  logic [W-1:0]   in_b,
    input  logic           cfg_load,
    input  logic [IBW-1:0] cfg_value,
    output logic           out_valid,
    output logic [W-1:0]   out_data
);
    logic                 s1_valid;
    rpfx_pkg::rpfx_op_e   s1_op;
    logic [W-1:0]         s1_a;
    logic [W-1:0]         s1_b;
    logic [IBW-1:0]       cur_ibits;
    logic [W-1:0]         mul_res;
    logic [W-1:0]         add_res;
    logic                 busy;

    // Busy: an operation is arriving or sits in the input stage.
    always_comb busy = in_valid || s1_valid;

    rpfx_in_stage #(.W(W)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_op    (op_sel),
        .in_a     (in_a),
        .in_b     (in_b),
        .s1_valid (s1_valid),
        .s1_op    (s1_op),
        .s1_a     (s1_a),
        .s1_b     (s1_b)
    );

    rpfx_cfg_reg #(.W(W), .IBW(IBW), .DEF_IB(DEF_IB)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .cfg_value (cfg_value),
        .busy      (busy),
        .ibits     (cur_ibits)
    );

    rpfx_mul_scale #(.W(W), .IBW(IBW)) u_mul (
        .mul_a   (s1_a),
        .mul_b   (s1_b),
        .ibits   (cur_ibits),
        .mul_res (mul_res)
    );

    // Plain wrapping add of the raw words.
    always_comb add_res = s1_a + s1_b;

    // Output register: pick the result of the staged operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid)
                out_data <= (s1_op == rpfx_pkg::OP_MUL) ? mul_res : add_res;
        end
    end
endmodule

// File: rtl/rpfx_unit_chk.sv
// Module: assertion checker for rpfx_unit, attached through bind.
// Assumes: it observes ports plus the integer-bits register.
module rpfx_unit_chk #(
    parameter int W   = 16,
    parameter int IBW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           op_sel,
    input logic [W-1:0]   in_a,
    input logic [W-1:0]   in_b,
    input logic           cfg_load,
    input logic [IBW-1:0] cfg_value,
    input logic           out_valid,
    input logic [W-1:0]   out_data,
    input logic [IBW-1:0] ibits
);
    // R1: reset clears the result strobe and restores the default setting.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0 && ibits == IBW'(8)));

    // R6: every accepted operation produces a strobe two edges later.
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R6: no strobe without an operation two edges earlier.
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    // R2: add result is the wrapped sum of the operands.
    a_r2_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sel) |=> ##1 (out_data == $past(in_a + in_b, 2)));

    // R8: a load colliding with an issue leaves the setting unchanged.
    a_r8_load_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && in_valid) |=> $stable(ibits));

    // R9: an out-of-range load leaves the setting unchanged.
    a_r9_range_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && cfg_value > IBW'(W)) |=> $stable(ibits));

    // R7: the setting always stays within 0..W.
    a_r7_setting_range: assert property (@(posedge clk) disable iff (!rst_n)
        ibits <= IBW'(W));
endmodule

bind rpfx_unit rpfx_unit_chk #(.W(W), .IBW(IBW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .in_a      (in_a),
    .in_b      (in_b),
    .cfg_load  (cfg_load),
    .cfg_value (cfg_value),
    .out_valid (out_valid),
    .out_data  (out_data),
    .ibits     (cur_ibits)
);

// File: tb/rpfx_unit_tb.sv
// Bench for rpfx_unit at W=16: a vector table at the default setting,
// then directed tests for configuration, collisions, streaming and reset.
module rpfx_unit_tb;
    localparam int W   = 16;
    localparam int IBW = 5;
    localparam int NV  = 8;

    // {op, a, b, expected} at 8 integer bits.
    localparam logic [48:0] VEC [NV] = '{
        {1'b0, 16'h0100, 16'h0200, 16'h0300},   // R2 add
        {1'b0, 16'h7FFF, 16'h0001, 16'h8000},   // R2 add wrap
        {1'b1, 16'h0100, 16'h0100, 16'h0100},   // R1/R3 1.0*1.0
        {1'b1, 16'h0180, 16'h0200, 16'h0300},   // R3 1.5*2.0
        {1'b1, 16'hFF00, 16'h0180, 16'hFE80},   // R3 -1.0*1.5
        {1'b1, 16'hFFFF, 16'h0001, 16'hFFFF},   // R4 floor
        {1'b1, 16'h7F00, 16'h0200, 16'hFE00},   // R5 wrap
        {1'b1, 16'h0001, 16'h0001, 16'h0000}    // R4 tiny product
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           op_sel = 1'b0;
    logic [W-1:0]   in_a = '0;
    logic [W-1:0]   in_b = '0;
    logic           cfg_load = 1'b0;
    logic [IBW-1:0] cfg_value = '0;
    logic           out_valid;
    logic [W-1:0]   out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rpfx_unit #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .in_a(in_a), .in_b(in_b), .cfg_load(cfg_load), .cfg_value(cfg_value),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation at a negedge and check it two edges later.
    task automatic do_op(input string req, input logic op, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [W-1:0] exp);
        op_sel = op; in_a = a; in_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " early strobe"}, {15'd0, out_valid}, 16'd0);
        @(negedge clk);
        chk({req, " strobe"}, {15'd0, out_valid}, 16'd1);
        chk(req, out_data, exp);
    endtask

    task automatic load(input logic [IBW-1:0] v);
        cfg_load = 1'b1; cfg_value = v;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset valid", {15'd0, out_valid}, 16'd0);
        chk("R1 reset data", out_data, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        // Table at default setting (R1 default, R2..R5)
        for (int i = 0; i < NV; i++)
            do_op($sformatf("R3 vector %0d", i), VEC[i][48], VEC[i][47:32],
                  VEC[i][31:16], VEC[i][15:0]);

        // R7: extremes of the setting
        load(5'd16);
        do_op("R7 ibits16", 1'b1, 16'h0003, 16'h0005, 16'h000F);
        load(5'd0);
        do_op("R7 ibits0", 1'b1, 16'h4000, 16'h0004, 16'h0001);
        do_op("R4 ibits0 negative", 1'b1, 16'hC000, 16'h0004, 16'hFFFF);
        do_op("R4 ibits0 floor", 1'b1, 16'h0001, 16'hFFFF, 16'hFFFF);
        do_op("R2 add ignores ibits", 1'b0, 16'h1234, 16'h0001, 16'h1235);

        // R9: out-of-range value ignored (stays at 0)
        load(5'd17);
        do_op("R9 reject 17", 1'b1, 16'h4000, 16'h0004, 16'h0001);
        load(5'd31);
        do_op("R9 reject 31", 1'b1, 16'h4000, 16'h0004, 16'h0001);

        // R7: mid value
        load(5'd12);
        do_op("R7 ibits12", 1'b1, 16'h0010, 16'h0010, 16'h0010);

        // R8: load on the same edge as an issue
        cfg_load = 1'b1; cfg_value = 5'd8;
        do_op("R8 collide op", 1'b1, 16'h0010, 16'h0010, 16'h0010);
        do_op("R8 collide after", 1'b1, 16'h0010, 16'h0010, 16'h0010);

        // R8: load while an operation is in the input stage
        op_sel = 1'b1; in_a = 16'h0010; in_b = 16'h0010; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; cfg_load = 1'b1; cfg_value = 5'd8;
        @(negedge clk);
        cfg_load = 1'b0;
        chk("R8 inflight result", out_data, 16'h0010);
        do_op("R8 inflight after", 1'b1, 16'h0010, 16'h0010, 16'h0010);

        // R6: back-to-back stream, back at 8 integer bits
        load(5'd8);
        op_sel = 1'b0; in_a = 16'h0001; in_b = 16'h0002; in_valid = 1'b1;
        @(negedge clk);
        op_sel = 1'b1; in_a = 16'h0200; in_b = 16'h0300;
        @(negedge clk);
        op_sel = 1'b0; in_a = 16'hFFFF; in_b = 16'hFFFF;
        chk("R6 stream first strobe", {15'd0, out_valid}, 16'd1);
        chk("R6 stream first", out_data, 16'h0003);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 stream second strobe", {15'd0, out_valid}, 16'd1);
        chk("R6 stream second", out_data, 16'h0600);
        @(negedge clk);
        chk("R6 stream third strobe", {15'd0, out_valid}, 16'd1);
        chk("R6 stream third", out_data, 16'hFFFE);
        @(negedge clk);
        chk("R6 stream idle", {15'd0, out_valid}, 16'd0);

        // R1: reset mid-run restores the default setting
        load(5'd12);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 rerun valid", {15'd0, out_valid}, 16'd0);
        chk("R1 rerun data", out_data, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        do_op("R1 default ibits", 1'b1, 16'h0100, 16'h0100, 16'h0100);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule